// File: doc/BRIEF.md
# Indirect Control and Status Register Front End

This block is the host-facing register front end of a descriptor-driven Ethernet controller. A host on a simple memory-mapped bus sees only two 16-bit locations: a selector port that chooses one of four internal registers and a data port that reads or writes the chosen register. Behind the pair sit a control/status word, two words that together hold a 24-bit initialization block address, and a three-bit bus-mode word.

The control/status word carries the commands that start, initialize and stop the controller and demand transmission. Each command leaves as a one-cycle pulse towards the engines. It also carries the event flags that the engines raise. These flags are cleared by writing ones, and two summary bits are derived from them: one for errors and one for interrupts. The interrupt output is the interrupt summary gated by an enable bit. The address and mode words are locked against writes while the controller runs.

Top module: `nic_csr_frontend`

## Requirements
- R1: A write with `host_port`=1 loads the register selector from `host_wdata[1:0]` (0 control/status, 1 address low, 2 address high, 3 mode); bits 15:2 are ignored. A read with `host_port`=1 returns the selector in bits 1:0 and zeros above.
- R2: The control/status word reads as: bit 0 init issued, bit 1 started, bit 2 stopped, bit 3 always 0, bit 4 transmitter on, bit 5 receiver on, bit 6 interrupt enable (loaded from every write of that word). A start write sets bits 1, 4 and 5. An init or start write clears bit 2.
- R3: `eng_events[6:0]` (0 init done, 1 transmit, 2 receive, 3 memory error, 4 missed frame, 5 heartbeat error, 6 babble) set bits 8 to 14. Writing 1 to one of those bits clears it, and writing 0 leaves it alone. An event arriving in the same cycle as its clear keeps the bit set.
- R4: Bit 7 reads as the OR of bits 8 to 14. Bit 15 reads as the OR of bits 11 to 14. `irq` is high exactly when bit 7 and bit 6 are both set.
- R5: Writing 1 to bit 0, 1, 2 or 3 of the control/status word raises `cmd_init`, `cmd_start`, `cmd_stop` or `cmd_tx_demand` for exactly the one cycle after the write edge.
- R6: A write with bit 2 set gives no init or start pulse even if bit 0 or 1 is also set. It clears bits 0, 1, 4, 5 and 8 to 14, including events arriving in that same cycle, and sets bit 2.
- R7: Register 1 holds `init_blk_addr[15:0]`. Register 2 holds `init_blk_addr[23:16]` from data bits 7:0, and its bits 15:8 are ignored and read 0. Register 3 holds `bus_mode[2:0]` (bit 2 byte swap, bit 1 address-latch control, bit 0 byte control), and its other bits read 0.
- R8: Writes to registers 1 to 3 take effect only while bit 2 of the control/status word is set. At other times they are ignored.
- R9: After reset the selector is 0, the control/status word reads 0x0004, registers 1 to 3 read 0, and all command pulses and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_port | input | 1 | 1 selects the selector port, 0 the data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the addressed port (combinational) |
| eng_events | input | 7 | Event inputs from the engines, one per event bit |
| cmd_init | output | 1 | Init pulse |
| cmd_start | output | 1 | Start pulse |
| cmd_stop | output | 1 | Stop pulse |
| cmd_tx_demand | output | 1 | Transmit demand pulse |
| irq | output | 1 | Interrupt request |
| init_blk_addr | output | 24 | Initialization block address |
| bus_mode | output | 3 | Bus-mode bits |

## Verification
The hardest situation to reach from the ports is a race at a single edge: an engine event that lands in the same cycle as a host write to the control/status word. When that write clears the same flag, the flag must survive. When the write is a stop, the flag must be lost. Random stimulus drives sparse engine events on every cycle while writes with random clear masks and occasional stop bits go to the data port, and directed steps force both races. A locked write to the address registers needs a started controller first, so the directed sequence starts the controller, attempts the write and reads back the unchanged value.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int DW        = 16;
    localparam int IBA_W     = 24;
    localparam int HI_W      = IBA_W - DW;
    localparam int SEL_W     = 2;
    localparam int NUM_EV    = 7;
    localparam int EV_LSB    = 8;
    localparam int MODE_W    = 3;

    // control/status word bit positions
    localparam int B_INIT    = 0;
    localparam int B_START   = 1;
    localparam int B_STOP    = 2;
    localparam int B_TDMD    = 3;
    localparam int B_INEA    = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_IBA_LO = 2'd1,
        SEL_IBA_HI = 2'd2,
        SEL_MODE   = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic init;
        logic start;
        logic stop;
        logic tdmd;
    } cmd_t;

    typedef struct packed {
        logic babble;
        logic hb_err;
        logic miss;
        logic mem_err;
        logic rx_ev;
        logic tx_ev;
        logic init_done;
    } ev_t;

    typedef struct packed {
        logic ctrl;
        logic iba_lo;
        logic iba_hi;
        logic mode;
    } wr_strobe_t;

    function automatic cmd_t decode_cmd(input logic [DW-1:0] d);
        cmd_t c;
        c.stop  = d[B_STOP];
        c.init  = d[B_INIT]  & ~d[B_STOP];
        c.start = d[B_START] & ~d[B_STOP];
        c.tdmd  = d[B_TDMD];
        return c;
    endfunction

    function automatic logic err_summary(input ev_t e);
        return e.babble | e.hb_err | e.miss | e.mem_err;
    endfunction

endpackage

// File: rtl/nic_csr_port_decode.sv
module nic_csr_port_decode
    import nic_csr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           host_cs,
    input  logic           host_we,
    input  logic           host_port,
    input  logic [DW-1:0]  host_wdata,
    output csr_sel_e       sel,
    output wr_strobe_t     wr
);
    csr_sel_e sel_q;
    logic     data_wr;
    logic     unused_upper;

    assign unused_upper = ^host_wdata[DW-1:SEL_W];

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= SEL_CTRL;
        else if (host_cs && host_we && host_port)
            sel_q <= csr_sel_e'(host_wdata[SEL_W-1:0]);
    end

    assign data_wr   = host_cs & host_we & ~host_port;
    assign wr.ctrl   = data_wr & (sel_q == SEL_CTRL);
    assign wr.iba_lo = data_wr & (sel_q == SEL_IBA_LO);
    assign wr.iba_hi = data_wr & (sel_q == SEL_IBA_HI);
    assign wr.mode   = data_wr & (sel_q == SEL_MODE);
    assign sel       = sel_q;
endmodule

// File: rtl/nic_csr_ctrl_word.sv
module nic_csr_ctrl_word
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [DW-1:0]     wdata,
    input  logic [NUM_EV-1:0] ev_in,
    output logic [DW-1:0]     ctrl_word,
    output logic              stopped,
    output logic              irq,
    output cmd_t              pulses
);
    cmd_t              cmd;
    logic [NUM_EV-1:0] ev_q, ev_d;
    logic              inited_q, started_q, stopped_q;
    logic              txon_q, rxon_q, inea_q;
    ev_t               ev_s;
    logic              unused_bits;

    assign unused_bits = ^{wdata[DW-1], wdata[7], wdata[5:4]};
    assign cmd = wr_ctrl ? decode_cmd(wdata) : '0;

    // per-flag next state: stop clears, event sets, written one clears
    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        always_comb begin
            if (cmd.stop)
                ev_d[i] = 1'b0;
            else if (ev_in[i])
                ev_d[i] = 1'b1;
            else if (wr_ctrl && wdata[EV_LSB+i])
                ev_d[i] = 1'b0;
            else
                ev_d[i] = ev_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q      <= '0;
            inited_q  <= 1'b0;
            started_q <= 1'b0;
            stopped_q <= 1'b1;
            txon_q    <= 1'b0;
            rxon_q    <= 1'b0;
            inea_q    <= 1'b0;
            pulses    <= '0;
        end else begin
            ev_q   <= ev_d;
            pulses <= cmd;
            if (wr_ctrl)
                inea_q <= wdata[B_INEA];
            if (cmd.stop) begin
                inited_q  <= 1'b0;
                started_q <= 1'b0;
                stopped_q <= 1'b1;
                txon_q    <= 1'b0;
                rxon_q    <= 1'b0;
            end else begin
                if (cmd.init) begin
                    inited_q  <= 1'b1;
                    stopped_q <= 1'b0;
                end
                if (cmd.start) begin
                    started_q <= 1'b1;
                    stopped_q <= 1'b0;
                    txon_q    <= 1'b1;
                    rxon_q    <= 1'b1;
                end
            end
        end
    end

    assign ev_s      = ev_t'(ev_q);
    assign ctrl_word = {err_summary(ev_s), ev_q, |ev_q, inea_q, rxon_q, txon_q,
                        1'b0, stopped_q, started_q, inited_q};
    assign stopped   = stopped_q;
    assign irq       = (|ev_q) & inea_q;
endmodule

// File: rtl/nic_csr_cfg_regs.sv
module nic_csr_cfg_regs
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr,
    input  logic              stopped,
    input  logic [DW-1:0]     wdata,
    output logic [IBA_W-1:0]  iba,
    output logic [MODE_W-1:0] mode,
    output logic [DW-1:0]     lo_word,
    output logic [DW-1:0]     hi_word,
    output logic [DW-1:0]     mode_word
);
    logic [IBA_W-1:0]  iba_q;
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            iba_q  <= '0;
            mode_q <= '0;
        end else if (stopped) begin
            if (wr.iba_lo) iba_q[DW-1:0]    <= wdata;
            if (wr.iba_hi) iba_q[IBA_W-1:DW] <= wdata[HI_W-1:0];
            if (wr.mode)   mode_q           <= wdata[MODE_W-1:0];
        end
    end

    assign iba       = iba_q;
    assign mode      = mode_q;
    assign lo_word   = iba_q[DW-1:0];
    assign hi_word   = {{(DW-HI_W){1'b0}}, iba_q[IBA_W-1:DW]};
    assign mode_word = {{(DW-MODE_W){1'b0}}, mode_q};
endmodule

// File: rtl/nic_csr_frontend.sv
module nic_csr_frontend
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_port,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic [6:0]        eng_events,
    output logic              cmd_init,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_tx_demand,
    output logic              irq,
    output logic [23:0]       init_blk_addr,
    output logic [2:0]        bus_mode
);
    csr_sel_e    reg_sel;
    wr_strobe_t  wr;
    cmd_t        pulses;
    logic        ctrl_stopped;
    logic [DW-1:0] ctrl_word, lo_word, hi_word, mode_word;

    nic_csr_port_decode u_decode (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
        .host_port(host_port), .host_wdata(host_wdata),
        .sel(reg_sel), .wr(wr)
    );

    nic_csr_ctrl_word u_ctrl (
        .clk(clk), .rst(rst), .wr_ctrl(wr.ctrl), .wdata(host_wdata),
        .ev_in(eng_events), .ctrl_word(ctrl_word), .stopped(ctrl_stopped),
        .irq(irq), .pulses(pulses)
    );

    nic_csr_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr(wr), .stopped(ctrl_stopped),
        .wdata(host_wdata), .iba(init_blk_addr), .mode(bus_mode),
        .lo_word(lo_word), .hi_word(hi_word), .mode_word(mode_word)
    );

    always_comb begin
        if (host_port)
            host_rdata = {{(DW-SEL_W){1'b0}}, reg_sel};
        else begin
            unique case (reg_sel)
                SEL_CTRL:   host_rdata = ctrl_word;
                SEL_IBA_LO: host_rdata = lo_word;
                SEL_IBA_HI: host_rdata = hi_word;
                default:    host_rdata = mode_word;
            endcase
        end
    end

    assign cmd_init      = pulses.init;
    assign cmd_start     = pulses.start;
    assign cmd_stop      = pulses.stop;
    assign cmd_tx_demand = pulses.tdmd;
endmodule

// File: rtl/nic_csr_checker.sv
module nic_csr_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_cs,
    input logic        host_we,
    input logic        host_port,
    input logic [15:0] host_wdata,
    input logic [6:0]  eng_events,
    input logic [1:0]  sel,
    input logic [15:0] ctrl_word,
    input logic        stopped,
    input logic        cmd_init,
    input logic        cmd_start,
    input logic        cmd_stop,
    input logic        irq,
    input logic [23:0] iba,
    input logic [2:0]  mode
);
    logic data_wr, stop_wr;
    assign data_wr = host_cs && host_we && !host_port;
    assign stop_wr = data_wr && (sel == 2'd0) && host_wdata[2];

    assert_stop_priority_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |-> (!cmd_init && !cmd_start));

    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |-> (ctrl_word[14:8] == 7'd0 && ctrl_word[5:4] == 2'd0 && ctrl_word[2]));

    assert_event_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (eng_events[6] && !stop_wr) |=> ctrl_word[14]);

    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (data_wr && sel != 2'd0 && !stopped) |=> ($stable(iba) && $stable(mode)));

    assert_tdmd_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[3] == 1'b0);

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_word[6] && ctrl_word[7]));
endmodule

bind nic_csr_frontend nic_csr_checker u_chk (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_port(host_port), .host_wdata(host_wdata), .eng_events(eng_events),
    .sel(reg_sel), .ctrl_word(ctrl_word), .stopped(ctrl_stopped),
    .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .irq(irq), .iba(init_blk_addr), .mode(bus_mode)
);

// File: tb/nic_csr_frontend_test.sv
`timescale 1ns/1ps
module nic_csr_frontend_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs = 1'b0, host_we = 1'b0, host_port = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [6:0]  eng_events = '0;
    logic        cmd_init, cmd_start, cmd_stop, cmd_tx_demand, irq;
    logic [23:0] init_blk_addr;
    logic [2:0]  bus_mode;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model state
    logic [1:0]  m_sel;
    logic [6:0]  m_ev;
    logic        m_inited, m_started, m_stopped, m_txon, m_rxon, m_inea;
    logic [23:0] m_iba;
    logic [2:0]  m_mode;
    logic [3:0]  m_pulse; // {init,start,stop,tdmd}

    always #2 clk = ~clk;

    nic_csr_frontend uut (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
        .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_events(eng_events), .cmd_init(cmd_init), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_tx_demand(cmd_tx_demand), .irq(irq),
        .init_blk_addr(init_blk_addr), .bus_mode(bus_mode)
    );

    function automatic logic [15:0] exp_ctrl();
        return {m_ev[6] | m_ev[5] | m_ev[4] | m_ev[3], m_ev, |m_ev, m_inea,
                m_rxon, m_txon, 1'b0, m_stopped, m_started, m_inited};
    endfunction

    function automatic logic [15:0] exp_rdata(input logic port);
        if (port) return {14'd0, m_sel};
        case (m_sel)
            2'd0: return exp_ctrl();
            2'd1: return m_iba[15:0];
            2'd2: return {8'd0, m_iba[23:16]};
            default: return {13'd0, m_mode};
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = 0; m_ev = 0; m_inited = 0; m_started = 0; m_stopped = 1;
        m_txon = 0; m_rxon = 0; m_inea = 0; m_iba = 0; m_mode = 0; m_pulse = 0;
    endtask

    task automatic step(input logic cs, input logic we, input logic port,
                        input logic [15:0] wd, input logic [6:0] ev, input string tag);
        logic stp;
        @(negedge clk);
        check("R5", "command pulses", {cmd_init, cmd_start, cmd_stop, cmd_tx_demand}, m_pulse);
        check("R4", "irq", irq, (|m_ev) & m_inea);
        check("R7", "init_blk_addr", init_blk_addr, m_iba);
        check("R7", "bus_mode", bus_mode, m_mode);
        host_cs = cs; host_we = we; host_port = port; host_wdata = wd; eng_events = ev;
        #1;
        check(tag, "host_rdata", host_rdata, exp_rdata(port));
        m_pulse = 4'd0;
        if (cs && we && port) begin
            m_sel = wd[1:0];
            m_ev = m_ev | ev;
        end else if (cs && we && m_sel == 2'd0) begin
            stp = wd[2];
            m_pulse = {wd[0] & ~stp, wd[1] & ~stp, stp, wd[3]};
            m_inea = wd[6];
            if (stp) begin
                m_ev = 0; m_inited = 0; m_started = 0; m_stopped = 1;
                m_txon = 0; m_rxon = 0;
            end else begin
                m_ev = (m_ev & ~wd[14:8]) | ev;
                if (wd[0]) begin m_inited = 1; m_stopped = 0; end
                if (wd[1]) begin m_started = 1; m_stopped = 0; m_txon = 1; m_rxon = 1; end
            end
        end else begin
            if (cs && we && m_stopped) begin
                if (m_sel == 2'd1) m_iba[15:0] = wd;
                if (m_sel == 2'd2) m_iba[23:16] = wd[7:0];
                if (m_sel == 2'd3) m_mode = wd[2:0];
            end
            m_ev = m_ev | ev;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] wd;
        logic [6:0]  ev;
        int          seed;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R9: reset state, control word 0x0004
        step(1, 0, 1, 16'h0, 7'h0, "R9");
        step(1, 0, 0, 16'h0, 7'h0, "R9");
        // R1: upper selector bits ignored, 0xFFFD selects register 1
        step(1, 1, 1, 16'hFFFD, 7'h0, "R1");
        step(1, 0, 1, 16'h0, 7'h0, "R1");
        step(1, 1, 0, 16'h1234, 7'h0, "R7");
        step(1, 0, 0, 16'h0, 7'h0, "R7");
        step(1, 1, 1, 16'h0002, 7'h0, "R1");
        step(1, 1, 0, 16'hABCD, 7'h0, "R7");
        step(1, 0, 0, 16'h0, 7'h0, "R7");
        step(1, 1, 1, 16'h0003, 7'h0, "R1");
        step(1, 1, 0, 16'hFFFF, 7'h0, "R7");
        step(1, 0, 0, 16'h0, 7'h0, "R7");
        // start the controller, interrupts enabled (R2, R5)
        step(1, 1, 1, 16'h0000, 7'h0, "R1");
        step(1, 1, 0, 16'h0042, 7'h0, "R2");
        step(1, 0, 0, 16'h0, 7'h0, "R2");
        // R8: locked address write while running
        step(1, 1, 1, 16'h0001, 7'h0, "R1");
        step(1, 1, 0, 16'h5555, 7'h0, "R8");
        step(1, 0, 0, 16'h0, 7'h0, "R8");
        step(1, 1, 1, 16'h0000, 7'h0, "R1");
        // R3/R4: raise all events, then clear with babble arriving together
        step(0, 0, 0, 16'h0, 7'h7F, "R3");
        step(1, 0, 0, 16'h0, 7'h0, "R4");
        step(1, 1, 0, 16'h7F48, 7'h40, "R3");
        step(1, 0, 0, 16'h0, 7'h0, "R3");
        step(1, 1, 0, 16'h0048, 7'h0, "R3");
        step(1, 0, 0, 16'h0, 7'h0, "R3");
        // transmit demand pulse, reads back 0 (R5, R2)
        step(1, 1, 0, 16'h0048, 7'h0, "R5");
        step(1, 0, 0, 16'h0, 7'h0, "R2");
        // R6: stop together with init and start, event in same cycle is lost
        step(1, 1, 0, 16'h0047, 7'h11, "R6");
        step(1, 0, 0, 16'h0, 7'h0, "R6");
        step(1, 0, 0, 16'h0, 7'h0, "R6");
        // random phase
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 4000; i++) begin
            int kind;
            kind = $urandom_range(0, 9);
            ev = ($urandom_range(0, 3) == 0) ? 7'($urandom) & 7'($urandom) : 7'h0;
            wd = 16'($urandom);
            if (kind < 2)
                step(1, 1, 1, wd, ev, "R1");
            else if (kind < 5) begin
                if ($urandom_range(0, 2) != 0) wd[2] = 1'b0;
                step(1, 1, 0, wd, ev, "R3");
            end else if (kind < 8)
                step(1, 0, $urandom_range(0, 1) == 1, wd, ev, "R2");
            else
                step(0, 0, 0, wd, ev, "R4");
        end
        step(0, 0, 0, 16'h0, 7'h0, "R4");
        finish_run();
    end
endmodule